// File: doc/BRIEF.md
# Two-Subpass Thinning Flag Engine

This block does one subpass of iterative parallel thinning on a binary image. Pixels arrive in raster order, one bit per accepted beat. The engine keeps the two most recent image rows in a shift chain, so it can form a 3x3 neighbourhood around each centre. It then tests that centre against the deletion rules of the selected subpass. A centre that passes has its linear address stored in a compact flag memory, and an up counter tracks how many are stored.

When the scan ends, the engine publishes the number of flagged pixels and a nonzero indication. The counter then runs downward and presents each stored address once, one per cycle, so that an external image memory can clear those pixels. Deletion is therefore deferred until the whole subpass has been scanned. The surrounding controller alternates subpass 1 and subpass 2 and stops when a complete pass flags nothing. Neither the image store nor that outer loop is part of this block.

Neighbours of a centre are named clockwise from north: P2 = north, P3 = north-east, P4 = east, P5 = south-east, P6 = south, P7 = south-west, P8 = west, P9 = north-west.

Top module: `thin_flag_engine`

## Requirements
- R1: A scan starts when `start_i` is high while the engine is idle. From then on, each cycle with `pix_valid_i` high takes one pixel. Pixel address is row*IMG_W+col, and the scan ends after IMG_W*IMG_H pixels. Idle beats between pixels do not change the result.
- R2: A centre is flagged only if its own value is 1.
- R3: A centre is flagged only if N, the number of set neighbours among P2..P9, satisfies 2 <= N <= 6.
- R4: A centre is flagged only if S = 1. S counts the 0-to-1 steps in the cyclic sequence P2,P3,...,P9,P2.
- R5: With `subpass_i` = 0 (subpass 1), P2&P4&P6 and P4&P6&P8 must both be 0. With `subpass_i` = 1 (subpass 2), P2&P4&P8 and P2&P6&P8 must both be 0. The pixels flagged are exactly those centres that meet R2 through R5 together.
- R6: A centre on the image border (row 0, row IMG_H-1, column 0, column IMG_W-1) is never flagged.
- R7: When the scan ends, `flag_cnt_o` gives the number of flagged pixels and `any_flag_o` is high exactly when that number is nonzero. Both values hold until the next scan ends.
- R8: Playback presents every flagged address exactly once on `play_addr_o`, one per cycle with `play_valid_o` high, in strictly descending address order. The first address appears two cycles after the last pixel is taken.
- R9: `done_o` pulses for one cycle in the cycle after the last address is presented, and `busy_o` is low from then on. With no flags, `done_o` comes two cycles after the last pixel is taken.
- R10: Pixels offered while idle are ignored, and so is `start_i` raised during a scan or playback. Neither changes the outputs or the subpass in use.
- R11: After reset, `busy_o`, `done_o`, `any_flag_o`, `play_valid_o` and `flag_cnt_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a subpass scan (honoured only when idle) |
| subpass_i | input | 1 | 0 = subpass 1 rules, 1 = subpass 2 rules, sampled at start |
| pix_valid_i | input | 1 | Pixel beat valid |
| pix_i | input | 1 | Binary pixel value |
| busy_o | output | 1 | Scan or playback in progress |
| done_o | output | 1 | One-cycle pulse at end of playback |
| any_flag_o | output | 1 | Last subpass flagged at least one pixel |
| flag_cnt_o | output | $clog2((IMG_W-2)*(IMG_H-2)+1) | Number of pixels flagged in last subpass |
| play_valid_o | output | 1 | Playback address valid |
| play_addr_o | output | $clog2(IMG_W*IMG_H) | Address of a flagged pixel to clear |

## Verification
A fault in the window alignment or in the neighbour order moves the flags to other pixels. The bench catches this at playback of the same subpass, within IMG_W*IMG_H+2 cycles of start, by comparing the set of addresses played back. A fault in the up/down counter shows in the length of playback, in its order or in `flag_cnt_o`. The bench measures the exact number of cycles from the last pixel to `done_o`, so a counter that is off by one shows as a wrong latency or a duplicated address.

// File: rtl/thin_flag_pkg.sv
package thin_flag_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_PLAY} tf_state_e;
endpackage

// File: rtl/tf_window.sv
module tf_window #(
  parameter int IMG_W = 16,
  parameter int IMG_H = 16,
  localparam int NPIX = IMG_W * IMG_H,
  localparam int AW   = $clog2(NPIX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          take_i,
  input  logic          pix_i,
  output logic          full_o,
  output logic          ev_v_o,
  output logic          ev_int_o,
  output logic          ev_last_o,
  output logic [AW-1:0] ev_addr_o,
  output logic          centre_o,
  output logic [7:0]    nb_o
);
  localparam int KW = $clog2(NPIX + 1);
  localparam int XW = $clog2(IMG_W);
  localparam int YW = $clog2(IMG_H);
  localparam int SL = 2 * IMG_W + 3;
  localparam logic [KW-1:0] K_OFF  = KW'(IMG_W + 1);
  localparam logic [KW-1:0] K_LAST = KW'(NPIX - 1);
  localparam logic [KW-1:0] K_END  = KW'(NPIX);
  localparam logic [XW-1:0] X_TWO  = XW'(2);
  localparam logic [XW-1:0] X_LAST = XW'(IMG_W - 1);
  localparam logic [YW-1:0] Y_TWO  = YW'(2);

  logic [SL-1:0] sr_q;
  logic [XW-1:0] col_q;
  logic [YW-1:0] row_q;
  logic [KW-1:0] k_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0; col_q <= '0; row_q <= '0; k_q <= '0;
      ev_v_o <= 1'b0; ev_int_o <= 1'b0; ev_last_o <= 1'b0; ev_addr_o <= '0;
    end else if (clear_i) begin
      sr_q <= '0; col_q <= '0; row_q <= '0; k_q <= '0;
      ev_v_o <= 1'b0;
    end else begin
      ev_v_o <= take_i;
      if (take_i) begin
        sr_q      <= {sr_q[SL-2:0], pix_i};
        // centre lags the newest pixel by one row and one column
        ev_int_o  <= (col_q >= X_TWO) && (row_q >= Y_TWO);
        ev_addr_o <= AW'(k_q - K_OFF);
        ev_last_o <= (k_q == K_LAST);
        k_q       <= k_q + 1'b1;
        if (col_q == X_LAST) begin
          col_q <= '0;
          row_q <= row_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  assign full_o   = (k_q == K_END);
  assign centre_o = sr_q[IMG_W+1];
  assign nb_o = {sr_q[2*IMG_W+2], sr_q[IMG_W+2], sr_q[2], sr_q[1],
                 sr_q[0], sr_q[IMG_W], sr_q[2*IMG_W], sr_q[2*IMG_W+1]};
endmodule

// File: rtl/tf_rule.sv
module tf_rule (
  input  logic [7:0] nb_i,   // [0]=P2 .. [7]=P9, clockwise from north
  input  logic       centre_i,
  input  logic       sub2_i,
  output logic       del_o
);
  logic [3:0] n_set;
  logic [3:0] n_rise;
  logic       p2, p4, p6, p8, ok_pass;

  always_comb begin
    n_set  = '0;
    n_rise = '0;
    for (int i = 0; i < 8; i++) begin
      n_set  = n_set + {3'b000, nb_i[i]};
      n_rise = n_rise + {3'b000, (!nb_i[i] && nb_i[(i+1)%8])};
    end
  end

  assign p2 = nb_i[0];
  assign p4 = nb_i[2];
  assign p6 = nb_i[4];
  assign p8 = nb_i[6];
  assign ok_pass = sub2_i ? (!(p2 && p4 && p8) && !(p2 && p6 && p8))
                          : (!(p2 && p4 && p6) && !(p4 && p6 && p8));
  assign del_o = centre_i && (n_set >= 4'd2) && (n_set <= 4'd6) &&
                 (n_rise == 4'd1) && ok_pass;
endmodule

// File: rtl/tf_flag_store.sv
module tf_flag_store #(
  parameter int DEPTH = 196,
  parameter int AW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          wr_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          play_i,
  output logic [CW-1:0] cnt_o,
  output logic          rd_valid_o,
  output logic [AW-1:0] rd_addr_o
);
  logic [AW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_dn;

  assign cnt_dn = cnt_q - 1'b1;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i) begin
    if (wr_i && !clear_i) mem[cnt_q[IW-1:0]] <= wr_addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      rd_valid_o <= 1'b0;
      rd_addr_o  <= '0;
    end else begin
      rd_valid_o <= 1'b0;
      if (clear_i) begin
        cnt_q <= '0;
      end else if (wr_i) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (play_i && cnt_q != '0) begin
        cnt_q      <= cnt_dn;
        rd_addr_o  <= mem[cnt_dn[IW-1:0]];
        rd_valid_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/thin_flag_engine.sv
module thin_flag_engine
  import thin_flag_pkg::*;
#(
  parameter int IMG_W = 16,
  parameter int IMG_H = 16,
  localparam int NPIX  = IMG_W * IMG_H,
  localparam int AW    = $clog2(NPIX),
  localparam int DEPTH = (IMG_W - 2) * (IMG_H - 2),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          subpass_i,
  input  logic          pix_valid_i,
  input  logic          pix_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          any_flag_o,
  output logic [CW-1:0] flag_cnt_o,
  output logic          play_valid_o,
  output logic [AW-1:0] play_addr_o
);
  tf_state_e     state_q;
  logic          sub2_q;
  logic          start_ok, take, full, wr, scan_end, play;
  logic          ev_v, ev_int, ev_last, centre, del;
  logic [AW-1:0] ev_addr;
  logic [7:0]    nb;
  logic [CW-1:0] cnt;

  assign start_ok = (state_q == ST_IDLE) && start_i;
  assign take     = (state_q == ST_SCAN) && pix_valid_i && !full;
  assign wr       = (state_q == ST_SCAN) && ev_v && ev_int && del;
  assign scan_end = (state_q == ST_SCAN) && ev_v && ev_last;
  assign play     = (state_q == ST_PLAY);

  tf_window #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_win (
    .clk_i, .rst_ni, .clear_i(start_ok), .take_i(take), .pix_i,
    .full_o(full), .ev_v_o(ev_v), .ev_int_o(ev_int), .ev_last_o(ev_last),
    .ev_addr_o(ev_addr), .centre_o(centre), .nb_o(nb)
  );

  tf_rule u_rule (.nb_i(nb), .centre_i(centre), .sub2_i(sub2_q), .del_o(del));

  tf_flag_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i, .rst_ni, .clear_i(start_ok), .wr_i(wr), .wr_addr_i(ev_addr),
    .play_i(play), .cnt_o(cnt), .rd_valid_o(play_valid_o), .rd_addr_o(play_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sub2_q     <= 1'b0;
      flag_cnt_o <= '0;
      any_flag_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SCAN;
          sub2_q  <= subpass_i;
        end
        ST_SCAN: if (scan_end) begin
          state_q    <= ST_PLAY;
          flag_cnt_o <= cnt + CW'(wr);
          any_flag_o <= (cnt != '0) || wr;
        end
        ST_PLAY: if (cnt == '0) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/thin_flag_chk.sv
module thin_flag_chk #(
  parameter int IMG_W = 16,
  parameter int IMG_H = 16,
  parameter int AW    = 8,
  parameter int CW    = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          any_flag_o,
  input logic [CW-1:0] flag_cnt_o,
  input logic          play_valid_o,
  input logic [AW-1:0] play_addr_o
);
  logic [CW-1:0] plays_q;
  int unsigned   pcol, prow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           plays_q <= '0;
    else if (done_o)       plays_q <= '0;
    else if (play_valid_o) plays_q <= plays_q + 1'b1;
  end

  assign pcol = int'(play_addr_o) % IMG_W;
  assign prow = int'(play_addr_o) / IMG_W;

  AST_PLAY_DESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    play_valid_o && $past(play_valid_o) |-> play_addr_o < $past(play_addr_o)); // R8
  AST_PLAY_INTERIOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    play_valid_o |-> (pcol != 0 && pcol != IMG_W-1 && prow != 0 && prow != IMG_H-1)); // R6
  AST_PLAY_TOTAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> plays_q == flag_cnt_o); // R8
  AST_ANY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> any_flag_o == (flag_cnt_o != '0)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R9
  AST_NO_PLAY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !play_valid_o); // R9
  AST_STATS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && $past(!busy_o) |-> $stable(flag_cnt_o) && $stable(any_flag_o)); // R7
endmodule

bind thin_flag_engine thin_flag_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H), .AW(AW), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .any_flag_o(any_flag_o), .flag_cnt_o(flag_cnt_o),
  .play_valid_o(play_valid_o), .play_addr_o(play_addr_o)
);

// File: tb/tb_thin_flag_engine.sv
module tb_thin_flag_engine;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int H = 8;
  localparam int CW = $clog2((W-2)*(H-2)+1);
  localparam logic [63:0] BORDER = 64'hFF81_8181_8181_81FF;
  localparam int NVEC = 8;
  // {subpass, image}; bit index = row*8+col
  localparam logic [64:0] VEC [NVEC] = '{
    {1'b0, 64'h0000_3C3C_3C3C_0000},
    {1'b1, 64'h0000_3C3C_3C3C_0000},
    {1'b0, 64'h0018_3C7E_7E3C_1800},
    {1'b1, 64'h0018_3C7E_7E3C_1800},
    {1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 64'h0000_0000_0007_0707},
    {1'b1, 64'h0000_0000_0000_0000},
    {1'b1, 64'h0010_1010_FE10_1000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, subpass = 1'b0, pix_valid = 1'b0, pix = 1'b0;
  logic busy, done, any_flag, play_valid;
  logic [CW-1:0] flag_cnt;
  logic [5:0] play_addr;
  int n_tests = 0, n_fail = 0;

  thin_flag_engine #(.IMG_W(W), .IMG_H(H)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .subpass_i(subpass),
    .pix_valid_i(pix_valid), .pix_i(pix), .busy_o(busy), .done_o(done),
    .any_flag_o(any_flag), .flag_cnt_o(flag_cnt),
    .play_valid_o(play_valid), .play_addr_o(play_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit px(input logic [63:0] im, input int r, input int c);
    if (r < 0 || r >= H || c < 0 || c >= W) return 1'b0;
    return im[r*W+c];
  endfunction

  function automatic logic [63:0] model(input logic [63:0] im, input bit s2);
    logic [63:0] m = '0;
    for (int r = 1; r < H-1; r++) begin
      for (int c = 1; c < W-1; c++) begin
        bit q [10];
        int n = 0, s = 0;
        q[2] = px(im, r-1, c);   q[3] = px(im, r-1, c+1);
        q[4] = px(im, r, c+1);   q[5] = px(im, r+1, c+1);
        q[6] = px(im, r+1, c);   q[7] = px(im, r+1, c-1);
        q[8] = px(im, r, c-1);   q[9] = px(im, r-1, c-1);
        for (int j = 2; j <= 9; j++) begin
          n += int'(q[j]);
          if (!q[j] && q[(j == 9) ? 2 : j+1]) s++;
        end
        if (px(im, r, c) && n >= 2 && n <= 6 && s == 1 &&
            (s2 ? !(q[2] && q[4] && q[8]) && !(q[2] && q[6] && q[8])
                : !(q[2] && q[4] && q[6]) && !(q[4] && q[6] && q[8])))
          m[r*W+c] = 1'b1;
      end
    end
    return m;
  endfunction

  task automatic run_pass(input logic [63:0] im, input bit s2, input bit gaps,
                          input bit poke, output logic [63:0] mask,
                          output bit order_ok, output int lat);
    int prev = 64;
    mask = '0; order_ok = 1'b1; lat = 0;
    @(negedge clk); start = 1'b1; subpass = s2;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < W*H; i++) begin
      if (gaps && (i % 2 == 1)) begin
        pix_valid = 1'b0; @(negedge clk);
      end
      pix_valid = 1'b1; pix = im[i];
      if (poke && i == 5) begin start = 1'b1; subpass = ~s2; end
      @(negedge clk);
      start = 1'b0;
    end
    pix_valid = 1'b0;
    while (!done && lat < 200) begin
      @(negedge clk); lat++;
      if (play_valid) begin
        if (mask[play_addr] || int'(play_addr) >= prev) order_ok = 1'b0;
        mask[play_addr] = 1'b1;
        prev = int'(play_addr);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] mask, exp_m, img, ref_img;
    bit ord;
    int lat, fc;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !any_flag && !play_valid, "R11", "status bits after reset",
        {busy, done, any_flag, play_valid}, 0);
    chk(flag_cnt == '0, "R11", "flag_cnt after reset", flag_cnt, 0);
    rst_n = 1'b1;

    // R10: pixels while idle are ignored
    repeat (8) begin @(negedge clk); pix_valid = 1'b1; pix = 1'b1; end
    @(negedge clk); pix_valid = 1'b0;
    chk(!busy && !play_valid && flag_cnt == '0, "R10", "idle pixels ignored",
        {busy, play_valid}, 0);

    for (int v = 0; v < NVEC; v++) begin
      img = VEC[v][63:0];
      exp_m = model(img, VEC[v][64]);
      run_pass(img, VEC[v][64], v == 3, v == 2, mask, ord, lat);
      fc = $countones(exp_m);
      // R1 gaps (v=3), R10 start during scan (v=2)
      chk(mask == exp_m, "R2/R3/R4/R5 R1 R10", $sformatf("vec %0d flagged set", v), mask, exp_m);
      chk((mask & BORDER) == '0, "R6", $sformatf("vec %0d border", v), mask & BORDER, 0);
      chk(flag_cnt == CW'(fc) && any_flag == (fc != 0), "R7",
          $sformatf("vec %0d count", v), flag_cnt, fc);
      chk(ord, "R8", $sformatf("vec %0d descending unique", v), ord, 1);
      chk(lat == 2 + fc, "R8 R9", $sformatf("vec %0d done latency", v), lat, 2 + fc);
      @(negedge clk);
      chk(!done && !busy, "R9", $sformatf("vec %0d done pulse", v), {done, busy}, 0);
    end

    // R7: stats hold while idle
    repeat (5) @(negedge clk);
    chk(flag_cnt == '0 && !any_flag, "R7", "stats held after empty pass", flag_cnt, 0);

    // R5: full iteration to convergence on a thick bar
    img = 64'h0000_7E7E_7E7E_0000;
    ref_img = img;
    for (int it = 0; it < 10; it++) begin
      logic [63:0] a, b;
      a = model(ref_img, 1'b0); ref_img &= ~a;
      b = model(ref_img, 1'b1); ref_img &= ~b;
      if (a == '0 && b == '0) break;
    end
    begin
      bit conv = 1'b0;
      for (int it = 0; it < 10 && !conv; it++) begin
        logic [63:0] m1, m2;
        run_pass(img, 1'b0, 1'b0, 1'b0, m1, ord, lat);
        chk(m1 == model(img, 1'b0), "R5", "iteration subpass 1", m1, model(img, 1'b0));
        img &= ~m1;
        run_pass(img, 1'b1, 1'b0, 1'b0, m2, ord, lat);
        chk(m2 == model(img, 1'b1), "R5", "iteration subpass 2", m2, model(img, 1'b1));
        img &= ~m2;
        if (m1 == '0 && m2 == '0) conv = 1'b1;
      end
      chk(conv, "R5", "iteration converges", conv, 1);
      chk(img == ref_img, "R5", "final skeleton", img, ref_img);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule